// File: doc/BRIEF.md
# Master Power Sequencing Timer

This block is the master timer of a power sequencer. It watches one enable, taken from one of two hardware enable pins or from a software control bit. Each change of that enable starts a sequence of eight timed slot events. Downstream rails, GPIO outputs and clocks listen for the slot number that matches their configuration. A rising enable is a power-up sequence. A falling enable is a power-down sequence, and in that sequence the controlled outputs go to their inactive state as their slot comes up.

The spacing between slot events comes from a 3-bit code, with period = 40 << code microseconds (40 us to 5120 us). Time is counted in pulses of an external one-microsecond tick. There are two period codes, one for the suspend sequence and one for the shutdown sequence. A system-state input chooses between them, and the code is latched when a sequence starts. If the enable reverses during a sequence, the running sequence is dropped and a new one starts from slot 0 in the new direction.

Top module: `seq_master_timer`

## Requirements
- R1: `src_sel` picks the enable: 0 selects `en0_pin`, 1 selects `en1_pin`, and 2 or 3 select `sw_enable`.
- R2: A rising edge of the selected enable produces exactly eight `slot_strobe` pulses carrying slot numbers 0,1,...,7 in ascending order, with `dir_up` = 1.
- R3: A falling edge of the selected enable produces the same eight ascending slot pulses, with `dir_up` = 0.
- R4: Slot 0 is strobed after P tick pulses counted from the start of the sequence, and each later slot after another P tick pulses, where P = 40 << code. The strobe appears in the clock cycle after the P-th tick.
- R5: When `state_shdn` = 0 at the start of a sequence, the code is `susp_code`. When it is 1, the code is `shdn_code`.
- R6: Changes to `susp_code`, `shdn_code` or `state_shdn` after a sequence has started do not change that sequence's spacing.
- R7: An edge of the selected enable while a sequence runs abandons that sequence. A new sequence starts in the new direction and strobes slot 0 first.
- R8: `busy` is high from the cycle after the enable edge up to and including the slot-7 strobe cycle, and low afterwards while no new edge comes. Each strobe lasts one cycle and occurs while `busy` is high.
- R9: Activity on the enable inputs that are not selected starts no sequence and does not disturb a running one.
- R10: After reset, `slot` = 0, `slot_strobe` = 0, `dir_up` = 0 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| en0_pin | input | 1 | Hardware enable pin 0 (asynchronous) |
| en1_pin | input | 1 | Hardware enable pin 1 (asynchronous) |
| sw_enable | input | 1 | Software enable bit (synchronous) |
| src_sel | input | 2 | Enable source select |
| susp_code | input | 3 | Period code for the suspend sequence |
| shdn_code | input | 3 | Period code for the shutdown sequence |
| state_shdn | input | 1 | 1 = shutdown sequence, 0 = suspend sequence |
| slot | output | 3 | Number of the slot most recently strobed |
| slot_strobe | output | 1 | One-cycle pulse marking a slot event |
| dir_up | output | 1 | 1 = power-up sequence, 0 = power-down |
| busy | output | 1 | Sequence in progress |

## Verification
If the tick counter holds a wrong value, the next strobe arrives early or late, so the tick count between two strobes is off at the very next slot. If the slot index is wrong, the next strobe carries the wrong number, or a ninth strobe appears, or `busy` stays high after slot 7, all within one period. If the latched direction or period is wrong after a reversal or a code change, the first strobe of the new sequence shows it. The scoreboard compares the slot number, direction and tick spacing of every strobe against the stream of items the driver expects.

// File: rtl/seqt_pkg.sv
package seqt_pkg;

  typedef enum logic [1:0] {
    SRC_PIN0  = 2'd0,
    SRC_PIN1  = 2'd1,
    SRC_SOFT  = 2'd2,
    SRC_SOFT2 = 2'd3
  } seqt_src_e;

  // Slot spacing in microsecond ticks: base doubled once per code step.
  function automatic int unsigned period_ticks(input int unsigned code,
                                               input int unsigned base_us);
    return base_us << code;
  endfunction

  // Largest spacing the code field can express.
  function automatic int unsigned max_period(input int unsigned code_w,
                                             input int unsigned base_us);
    return base_us << ((1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/seqt_src_sel.sv
module seqt_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en0_pin,
  input  logic       en1_pin,
  input  logic       sw_enable,
  input  logic [1:0] src_sel,
  output logic       sel_en
);
  import seqt_pkg::*;

  logic en0_s, en1_s;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign en0_s = en0_pin;
      assign en1_s = en1_pin;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh0, sh1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh0 <= '0;
          sh1 <= '0;
        end else begin
          sh0 <= (sh0 << 1) | SYNC_STAGES'(en0_pin);
          sh1 <= (sh1 << 1) | SYNC_STAGES'(en1_pin);
        end
      end
      assign en0_s = sh0[SYNC_STAGES-1];
      assign en1_s = sh1[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    unique case (seqt_src_e'(src_sel))
      SRC_PIN0: sel_en = en0_s;
      SRC_PIN1: sel_en = en1_s;
      default:  sel_en = sw_enable;
    endcase
  end

endmodule

// File: rtl/seqt_edge.sv
module seqt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_en,
  output logic edge_evt,
  output logic level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= sel_en;
  end

  assign edge_evt = sel_en ^ level_q;

  // R7: after any edge the stored level follows the new enable value
  assert_level_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (level_q == $past(sel_en)));

endmodule

// File: rtl/seqt_slot_timer.sv
module seqt_slot_timer #(
  parameter int CNT_W  = 13,
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              start,
  input  logic [CNT_W-1:0]  period,
  output logic              fire,
  output logic [SLOT_W-1:0] fire_idx,
  output logic              running
);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(SLOTS - 1);

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  per_q;
  logic [SLOT_W-1:0] idx_q;
  logic              period_done;

  assign period_done = (cnt_q == per_q - CNT_W'(1));
  assign fire        = run_q && us_tick && period_done && !start;
  assign fire_idx    = idx_q;
  assign running     = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      per_q <= period;
      idx_q <= '0;
    end else if (run_q && us_tick) begin
      if (period_done) begin
        cnt_q <= '0;
        idx_q <= idx_q + SLOT_W'(1);
        if (idx_q == LAST_IDX) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4: the tick counter never passes the latched period
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  // R6: the latched period stays fixed for the life of a sequence
  assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start) |=> (per_q == $past(per_q)));
  // R7: a start always restarts from the first slot
  assert_restart_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && idx_q == '0 && cnt_q == '0));

endmodule

// File: rtl/seq_master_timer.sv
module seq_master_timer #(
  parameter int BASE_US     = 40,
  parameter int CODE_W      = 3,
  parameter int SLOTS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       us_tick,
  input  logic                       en0_pin,
  input  logic                       en1_pin,
  input  logic                       sw_enable,
  input  logic [1:0]                 src_sel,
  input  logic [CODE_W-1:0]          susp_code,
  input  logic [CODE_W-1:0]          shdn_code,
  input  logic                       state_shdn,
  output logic [$clog2(SLOTS)-1:0]   slot,
  output logic                       slot_strobe,
  output logic                       dir_up,
  output logic                       busy
);
  import seqt_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(max_period(CODE_W, BASE_US) + 1);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(SLOTS - 1);

  logic              sel_en;
  logic              edge_evt;
  logic              level_q;
  logic [CODE_W-1:0] code_sel;
  logic [CNT_W-1:0]  period;
  logic              fire;
  logic [SLOT_W-1:0] fire_idx;
  logic              running;
  logic              strobe_q;
  logic [SLOT_W-1:0] slot_q;
  logic              dir_q;

  seqt_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .en0_pin   (en0_pin),
    .en1_pin   (en1_pin),
    .sw_enable (sw_enable),
    .src_sel   (src_sel),
    .sel_en    (sel_en)
  );

  seqt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_en   (sel_en),
    .edge_evt (edge_evt),
    .level_q  (level_q)
  );

  assign code_sel = state_shdn ? shdn_code : susp_code;
  assign period   = CNT_W'(period_ticks(int'(code_sel), BASE_US));

  seqt_slot_timer #(.CNT_W(CNT_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .start    (edge_evt),
    .period   (period),
    .fire     (fire),
    .fire_idx (fire_idx),
    .running  (running)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      slot_q   <= '0;
      dir_q    <= 1'b0;
    end else begin
      strobe_q <= fire;
      if (edge_evt) begin
        slot_q <= '0;
        dir_q  <= sel_en;
      end else if (fire) begin
        slot_q <= fire_idx;
      end
    end
  end

  assign slot        = slot_q;
  assign slot_strobe = strobe_q;
  assign dir_up      = dir_q;
  assign busy        = running | strobe_q;

  // R8: strobes only inside a busy window
  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe |-> busy);
  // R8: a strobe is a single-cycle pulse
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe |=> !slot_strobe);
  // R8: busy drops right after the last slot when no new edge arrives
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && slot == LAST_IDX && !edge_evt) |=> !busy);
  // R2: an edge raises busy with the direction taken from the new level
  assert_edge_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (busy && !slot_strobe && dir_up == $past(sel_en)));

endmodule

// File: tb/seq_master_timer_test.sv
`timescale 1ns/1ps
module seq_master_timer_test;

  typedef struct {
    int slot;
    bit up;
    int ticks;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       en0_pin = 1'b0, en1_pin = 1'b0, sw_enable = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [2:0] susp_code = 3'd0, shdn_code = 3'd0;
  logic       state_shdn = 1'b0;
  logic [2:0] slot;
  logic       slot_strobe, dir_up, busy;

  int  checks = 0, errors = 0;
  exp_t q[$];
  int  tcnt = 0, seen = 0, gap = 2, tick_ctr = 0;
  bit  hold = 1'b1, restart_req = 1'b0, after_last = 1'b0;

  seq_master_timer uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .en0_pin(en0_pin), .en1_pin(en1_pin), .sw_enable(sw_enable),
    .src_sel(src_sel), .susp_code(susp_code), .shdn_code(shdn_code),
    .state_shdn(state_shdn), .slot(slot), .slot_strobe(slot_strobe),
    .dir_up(dir_up), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // tick generator, driven just after the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick_ctr++;
      us_tick = !hold && (tick_ctr % gap == 0);
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (restart_req) begin
          tcnt = 0;
          restart_req = 1'b0;
        end
        if (after_last) begin
          after_last = 1'b0;
          if (q.size() == 0) chk(busy == 1'b0, "R8 busy after slot 7", busy, 0);
        end
        if (slot_strobe) begin
          seen++;
          if (q.size() == 0) begin
            chk(1'b0, "R2/R3 unexpected strobe", slot, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(slot == e.slot, "R2/R3 slot order", slot, e.slot);
            chk(dir_up == e.up, e.up ? "R2 direction" : "R3 direction", dir_up, e.up);
            chk(tcnt == e.ticks, "R4/R5/R6 spacing", tcnt, e.ticks);
            chk(busy == 1'b1, "R8 busy at strobe", busy, 1);
            if (e.slot == 7) after_last = 1'b1;
          end
          tcnt = 0;
        end
        if (us_tick) tcnt++;
      end
    end
  end

  // driver: freeze ticks, queue expectations, apply the edge, resume ticks
  task automatic start_seq(input int which, input bit level, input bit up, input int code);
    hold = 1'b1;
    step(4);
    q.delete();
    for (int s = 0; s < 8; s++) begin
      exp_t e;
      e.slot = s; e.up = up; e.ticks = 40 << code;
      q.push_back(e);
    end
    restart_req = 1'b1;
    case (which)
      0: en0_pin = level;
      1: en1_pin = level;
      default: sw_enable = level;
    endcase
    step(5);
    hold = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    while (q.size() != 0) step(1);
    step(3);
    chk(busy == 1'b0, req, busy, 0);
    chk(slot_strobe == 1'b0, req, slot_strobe, 0);
  endtask

  initial begin
    step(3);
    // R10: reset state
    chk(slot == 3'd0, "R10 slot", slot, 0);
    chk(slot_strobe == 1'b0, "R10 strobe", slot_strobe, 0);
    chk(dir_up == 1'b0, "R10 dir", dir_up, 0);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    rst_n = 1'b1;
    step(5);

    // R1 R2 R4: pin 0 selected, rise, suspend code 0
    src_sel = 2'd0; susp_code = 3'd0; state_shdn = 1'b0; gap = 2;
    start_seq(0, 1'b1, 1'b1, 0);
    wait_idle("R8 idle after up");

    // R3 R5: fall on pin 0, shutdown code 1
    state_shdn = 1'b1; shdn_code = 3'd1;
    start_seq(0, 1'b0, 1'b0, 1);
    wait_idle("R8 idle after down");

    // R1 R6 R9: pin 1 selected, codes change and pin 0 toggles mid-sequence
    src_sel = 2'd1; state_shdn = 1'b0; susp_code = 3'd2;
    start_seq(1, 1'b1, 1'b1, 2);
    step(200);
    susp_code = 3'd3; state_shdn = 1'b1; shdn_code = 3'd5;
    en0_pin = 1'b1; step(20); en0_pin = 1'b0; step(20);
    state_shdn = 1'b0;
    wait_idle("R9 idle after pin1 up");

    // R9: idle activity on unselected pin
    en0_pin = 1'b1; step(30);
    chk(busy == 1'b0, "R9 idle pin0 ignored", busy, 0);
    en0_pin = 1'b0; step(30);
    chk(busy == 1'b0, "R9 idle pin0 ignored", busy, 0);

    // R7: reversal during a power-down sequence (code 3)
    start_seq(1, 1'b0, 1'b0, 3);
    while (seen < 27) step(1);
    start_seq(1, 1'b1, 1'b1, 3);
    wait_idle("R7 idle after reversal");

    // R1: software source, longest shutdown period, pins toggling
    sw_enable = 1'b1; step(2);
    src_sel = 2'd2; state_shdn = 1'b1; shdn_code = 3'd7; gap = 1;
    step(10);
    start_seq(2, 1'b0, 1'b0, 7);
    step(3000);
    en1_pin = 1'b0; en0_pin = 1'b1; step(50);
    en0_pin = 1'b0;
    wait_idle("R9 idle after sw down");

    // R1: select value 3 also uses the software bit
    src_sel = 2'd3; state_shdn = 1'b0; susp_code = 3'd0; gap = 2;
    step(10);
    chk(busy == 1'b0, "R1 source switch no edge", busy, 0);
    start_seq(2, 1'b1, 1'b1, 0);
    wait_idle("R1 idle after alias up");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule